// File: doc/BRIEF.md
# Software Interrupt Dispatcher

This block records inter-processor interrupts that software raises by writing a command word. Any core may write the word. The command names an interrupt number from 0 to 15, gives an 8-bit list of cores and selects how the target set is formed. The block ANDs the chosen targets with a per-core interface-enable vector. It then ORs one pending bit for each remaining target into that interrupt number's pending word. The bit for a target sits in the row of the core that wrote the command.

Each interrupt number owns a 64-bit pending word: 8 source rows of 8 target bits. The whole matrix is driven out flat so that the acknowledge and priority logic can scan it. When the acknowledge logic takes an interrupt, it retires one pending bit through a clear port. The clear port names the interrupt number, the source and the target. A clear may arrive in the same cycle as a write. If both touch the same bit, the write wins. The new state appears on the output one clock edge after the write or the clear.

Top module: `sgi_dispatch`

## Requirements
- R1: After reset every bit of `pend_o` is 0.
- R2: Command fields: number in `wr_data[3:0]`, core list in `wr_data[23:16]`, selector in `wr_data[25:24]`. With selector 0, each core c set in the list gets bit `64*n + 8*s + c` of `pend_o` set one edge after the write. Here n is the number and s is `wr_core`.
- R3: Selector 1 targets every enabled core other than the writer, whatever the list holds.
- R4: Selector 2 targets the writer alone, whatever the list holds.
- R5: Selector 3 leaves `pend_o` unchanged.
- R6: A core c with `if_en[c]` low at the write gets no pending bit under any selector.
- R7: A write only sets bits. Every bit that was set before the write stays set.
- R8: A clear with `clr_en` high resets exactly bit `64*clr_id + 8*clr_src + clr_tgt` one edge later and leaves all other bits as they were.
- R9: When a write and a clear in the same cycle address the same bit, the bit ends up set. A clear of a different bit in that cycle still takes effect.
- R10: With `wr_en` and `clr_en` both low, `pend_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Command write strobe |
| wr_data | input | 32 | Command word |
| wr_core | input | 3 | Number of the core doing the write |
| if_en | input | NUM_CORES | Per-core interface enable |
| clr_en | input | 1 | Clear strobe from the acknowledge logic |
| clr_id | input | 4 | Interrupt number to clear |
| clr_src | input | 3 | Source row to clear |
| clr_tgt | input | 3 | Target bit to clear |
| pend_o | output | NUM_IDS*64 | Pending matrix, word n at bits [64n+63:64n] |

## Verification
The pending matrix is the only state, and it is on the output in full. A wrong bit therefore shows on `pend_o` at the edge right after the write or clear that caused it. It does not hide until a later acknowledge. A selector decoded wrongly, a target that skips the enable filter, or a bit placed in the wrong row shows up as a mismatch against the bench's own matrix in that same cycle. A dropped bit or a stuck bit is caught on the next compare, and every operation is followed by one.

// File: rtl/sgi_pkg.sv
package sgi_pkg;

    localparam int SLOT_CORES = 8;
    localparam int SLOT_W     = SLOT_CORES * SLOT_CORES;
    localparam int CORE_W     = $clog2(SLOT_CORES);
    localparam int ID_W       = 4;

    localparam int ID_LSB     = 0;
    localparam int LIST_LSB   = 16;
    localparam int SEL_LSB    = 24;

    typedef enum logic [1:0] {
        SEL_LISTED = 2'd0,
        SEL_OTHERS = 2'd1,
        SEL_SELF   = 2'd2,
        SEL_RSVD   = 2'd3
    } tgt_sel_e;

    typedef struct packed {
        logic                  valid;
        logic [ID_W-1:0]       id;
        logic [CORE_W-1:0]     src;
        logic [SLOT_CORES-1:0] tgt;
    } sgi_cmd_t;

endpackage

// File: rtl/sgi_cmd_decode.sv
module sgi_cmd_decode
    import sgi_pkg::*;
#(
    parameter int NUM_CORES = 8
) (
    input  logic                 wr_en,
    input  logic [31:0]          wr_data,
    input  logic [CORE_W-1:0]    wr_core,
    input  logic [NUM_CORES-1:0] if_en,
    output sgi_cmd_t             cmd
);

    tgt_sel_e              sel;
    logic [SLOT_CORES-1:0] self_mask;
    logic [SLOT_CORES-1:0] raw_mask;
    logic [SLOT_CORES-1:0] en_mask;

    always_comb begin
        sel       = tgt_sel_e'(wr_data[SEL_LSB +: 2]);
        self_mask = SLOT_CORES'(1) << wr_core;
        case (sel)
            SEL_LISTED: raw_mask = wr_data[LIST_LSB +: SLOT_CORES];
            SEL_OTHERS: raw_mask = ~self_mask;
            SEL_SELF:   raw_mask = self_mask;
            default:    raw_mask = '0;
        endcase
    end

    for (genvar c = 0; c < SLOT_CORES; c++) begin : g_en
        if (c < NUM_CORES) begin : g_live
            assign en_mask[c] = if_en[c];
        end else begin : g_absent
            assign en_mask[c] = 1'b0;
        end
    end

    always_comb begin
        cmd.valid = wr_en && (sel != SEL_RSVD);
        cmd.id    = wr_data[ID_LSB +: ID_W];
        cmd.src   = wr_core;
        cmd.tgt   = raw_mask & en_mask;
    end

endmodule

// File: rtl/sgi_slot_masks.sv
module sgi_slot_masks
    import sgi_pkg::*;
#(
    parameter int NUM_IDS = 16
) (
    input  sgi_cmd_t                       cmd,
    input  logic                           clr_en,
    input  logic [ID_W-1:0]                clr_id,
    input  logic [CORE_W-1:0]              clr_src,
    input  logic [CORE_W-1:0]              clr_tgt,
    output logic [NUM_IDS-1:0][SLOT_W-1:0] set_vec,
    output logic [NUM_IDS-1:0][SLOT_W-1:0] clr_vec
);

    logic [SLOT_W-1:0] set_row;
    logic [SLOT_W-1:0] clr_one;

    always_comb begin
        set_row = SLOT_W'(cmd.tgt) << (SLOT_CORES * int'(cmd.src));
        clr_one = SLOT_W'(1) << (int'(clr_tgt) + SLOT_CORES * int'(clr_src));
    end

    for (genvar i = 0; i < NUM_IDS; i++) begin : g_slot
        assign set_vec[i] = (cmd.valid && (int'(cmd.id) == i)) ? set_row : '0;
        assign clr_vec[i] = (clr_en && (int'(clr_id) == i)) ? clr_one : '0;
    end

endmodule

// File: rtl/sgi_pend_bank.sv
module sgi_pend_bank
    import sgi_pkg::*;
#(
    parameter int NUM_IDS = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_IDS-1:0][SLOT_W-1:0] set_vec,
    input  logic [NUM_IDS-1:0][SLOT_W-1:0] clr_vec,
    output logic [NUM_IDS-1:0][SLOT_W-1:0] pend
);

    typedef struct packed {
        logic [NUM_IDS-1:0][SLOT_W-1:0] pend;
    } bank_t;

    bank_t bank_d;
    bank_t bank_q;

    always_comb begin
        bank_d = bank_q;
        for (int i = 0; i < NUM_IDS; i++) begin
            bank_d.pend[i] = (bank_q.pend[i] & ~clr_vec[i]) | set_vec[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign pend = bank_q.pend;

endmodule

// File: rtl/sgi_dispatch.sv
module sgi_dispatch
    import sgi_pkg::*;
#(
    parameter int NUM_IDS   = 16,
    parameter int NUM_CORES = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [31:0]                 wr_data,
    input  logic [2:0]                  wr_core,
    input  logic [NUM_CORES-1:0]        if_en,
    input  logic                        clr_en,
    input  logic [3:0]                  clr_id,
    input  logic [2:0]                  clr_src,
    input  logic [2:0]                  clr_tgt,
    output logic [NUM_IDS*SLOT_W-1:0]   pend_o
);

    sgi_cmd_t                       cmd;
    logic [NUM_IDS-1:0][SLOT_W-1:0] set_vec;
    logic [NUM_IDS-1:0][SLOT_W-1:0] clr_vec;
    logic [NUM_IDS-1:0][SLOT_W-1:0] pend;

    sgi_cmd_decode #(.NUM_CORES(NUM_CORES)) u_decode (
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .wr_core (wr_core),
        .if_en   (if_en),
        .cmd     (cmd)
    );

    sgi_slot_masks #(.NUM_IDS(NUM_IDS)) u_masks (
        .cmd     (cmd),
        .clr_en  (clr_en),
        .clr_id  (clr_id),
        .clr_src (clr_src),
        .clr_tgt (clr_tgt),
        .set_vec (set_vec),
        .clr_vec (clr_vec)
    );

    sgi_pend_bank #(.NUM_IDS(NUM_IDS)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .pend    (pend)
    );

    assign pend_o = pend;

endmodule

// File: rtl/sgi_dispatch_chk.sv
module sgi_dispatch_chk
    import sgi_pkg::*;
#(
    parameter int NUM_IDS   = 16,
    parameter int NUM_CORES = 8
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      wr_en,
    input logic [31:0]               wr_data,
    input logic [2:0]                wr_core,
    input logic [NUM_CORES-1:0]      if_en,
    input logic                      clr_en,
    input logic [3:0]                clr_id,
    input logic [2:0]                clr_src,
    input logic [2:0]                clr_tgt,
    input logic [NUM_IDS*SLOT_W-1:0] pend_o
);

    localparam int TOT_W = NUM_IDS * SLOT_W;

    logic [TOT_W-1:0] row_mask;
    logic [TOT_W-1:0] en_rep;
    logic [TOT_W-1:0] clr_bit;
    logic             is_rsvd;

    always_comb begin
        row_mask = '0;
        if (int'(wr_data[3:0]) < NUM_IDS) begin
            row_mask[SLOT_W*int'(wr_data[3:0]) + SLOT_CORES*int'(wr_core) +: SLOT_CORES] = '1;
        end
        en_rep = '0;
        for (int k = 0; k < NUM_IDS * SLOT_CORES; k++) begin
            for (int c = 0; c < NUM_CORES; c++) begin
                en_rep[k*SLOT_CORES + c] = if_en[c];
            end
        end
        clr_bit = '0;
        if (int'(clr_id) < NUM_IDS) begin
            clr_bit[SLOT_W*int'(clr_id) + SLOT_CORES*int'(clr_src) + int'(clr_tgt)] = 1'b1;
        end
        is_rsvd = (wr_data[25:24] == 2'd3);
    end

    // R10: idle cycle keeps the matrix
    a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !clr_en) |=> $stable(pend_o));

    // R5: reserved selector changes nothing
    a_r5_rsvd_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && is_rsvd && !clr_en) |=> $stable(pend_o));

    // R7: without a clear, no bit falls
    a_r7_only_sets: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_en |=> ((pend_o & $past(pend_o)) == $past(pend_o)));

    // R2: new bits only in the writer's row of the written number
    a_r2_row_only: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_o & ~$past(pend_o) & ~$past(wr_en ? row_mask : '0)) == '0));

    // R6: disabled targets never gain a bit
    a_r6_disabled_target: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_o & ~$past(pend_o) & ~$past(en_rep)) == '0));

    // R8: a clear with no write leaves its bit low
    a_r8_clear_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !wr_en) |=> ((pend_o & $past(clr_bit)) == '0));

endmodule

bind sgi_dispatch sgi_dispatch_chk #(.NUM_IDS(NUM_IDS), .NUM_CORES(NUM_CORES)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .wr_core (wr_core),
    .if_en   (if_en),
    .clr_en  (clr_en),
    .clr_id  (clr_id),
    .clr_src (clr_src),
    .clr_tgt (clr_tgt),
    .pend_o  (pend_o)
);

// File: tb/sgi_dispatch_bench.sv
`timescale 1ns/1ps
module sgi_dispatch_bench;

    localparam int NI = 16;
    localparam int NC = 8;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 wr_en = 1'b0;
    logic [31:0]          wr_data = '0;
    logic [2:0]           wr_core = '0;
    logic [NC-1:0]        if_en = '0;
    logic                 clr_en = 1'b0;
    logic [3:0]           clr_id = '0;
    logic [2:0]           clr_src = '0;
    logic [2:0]           clr_tgt = '0;
    logic [NI*64-1:0]     pend_o;

    logic [NI-1:0][63:0]  mdl;
    int                   n_chk = 0;
    int                   n_bad = 0;
    bit                   done = 1'b0;

    always #10 clk = ~clk;

    sgi_dispatch #(.NUM_IDS(NI), .NUM_CORES(NC)) u_sgi_dispatch (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .wr_core(wr_core), .if_en(if_en), .clr_en(clr_en), .clr_id(clr_id),
        .clr_src(clr_src), .clr_tgt(clr_tgt), .pend_o(pend_o)
    );

    function automatic logic [7:0] exp_targets(logic [31:0] d, logic [2:0] core,
                                               logic [NC-1:0] en);
        logic [7:0] self_b = 8'd1 << core;
        logic [7:0] t;
        case (d[25:24])
            2'd0:    t = d[23:16];
            2'd1:    t = ~self_b;
            2'd2:    t = self_b;
            default: t = 8'd0;
        endcase
        return t & en;
    endfunction

    function automatic logic [31:0] mk(int id, int list, int sel);
        return (32'(sel) << 24) | (32'(list & 8'hFF) << 16) | 32'(id & 15);
    endfunction

    task automatic compare(string req);
        n_chk++;
        if (pend_o !== mdl) begin
            n_bad++;
            for (int i = 0; i < NI; i++) begin
                if (pend_o[i*64 +: 64] !== mdl[i]) begin
                    $display("FAIL %s: id %0d got %h expected %h", req, i,
                             pend_o[i*64 +: 64], mdl[i]);
                    break;
                end
            end
        end
    endtask

    // one cycle of stimulus, model update, compare after the edge
    task automatic step(bit we, logic [31:0] d, logic [2:0] core, logic [NC-1:0] en,
                        bit ce, logic [3:0] cid, logic [2:0] cs, logic [2:0] ct,
                        string req);
        logic [7:0] t;
        wr_en = we; wr_data = d; wr_core = core; if_en = en;
        clr_en = ce; clr_id = cid; clr_src = cs; clr_tgt = ct;
        if (ce) mdl[cid][int'(ct) + 8*int'(cs)] = 1'b0;
        if (we) begin
            t = exp_targets(d, core, en);
            mdl[d[3:0]][8*int'(core) +: 8] = mdl[d[3:0]][8*int'(core) +: 8] | t;
        end
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; clr_en = 1'b0;
        compare(req);
    endtask

    task automatic wr(logic [31:0] d, logic [2:0] core, logic [NC-1:0] en, string req);
        step(1'b1, d, core, en, 1'b0, 4'd0, 3'd0, 3'd0, req);
    endtask

    task automatic clr(logic [3:0] cid, logic [2:0] cs, logic [2:0] ct, string req);
        step(1'b0, 32'd0, 3'd0, '1, 1'b1, cid, cs, ct, req);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        finish_run();
    end

    initial begin
        int seed;
        mdl = '0;
        seed = $urandom(32'h5A17);
        repeat (3) @(negedge clk);
        compare("R1 during reset");
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1 after reset");

        // R2: listed cores, writer 2, number 5
        wr(mk(5, 8'h81, 0), 3'd2, 8'hFF, "R2 listed");
        // R3: everyone enabled but the writer
        wr(mk(1, 8'h00, 1), 3'd3, 8'hFF, "R3 others");
        wr(mk(7, 8'h00, 1), 3'd0, 8'h3C, "R3 others with enables");
        // R4: writer only, list ignored
        wr(mk(9, 8'h0F, 2), 3'd6, 8'hFF, "R4 self");
        // R5: reserved selector
        wr(mk(5, 8'hFF, 3), 3'd4, 8'hFF, "R5 reserved");
        // R6: disabled targets filtered, disabled writer under self
        wr(mk(2, 8'hFF, 0), 3'd1, 8'h0F, "R6 listed filtered");
        wr(mk(3, 8'hFF, 2), 3'd7, 8'h7F, "R6 self disabled");
        // R7: another source on the same number keeps earlier bits
        wr(mk(5, 8'h42, 0), 3'd5, 8'hFF, "R7 other source");
        wr(mk(5, 8'h01, 0), 3'd2, 8'hFF, "R7 repeat set");
        // R8: clear exactly one bit
        clr(4'd5, 3'd2, 3'd7, "R8 clear one");
        clr(4'd5, 3'd2, 3'd7, "R8 clear already clear");
        // R9: set and clear of the same bit; then of different bits
        step(1'b1, mk(5, 8'h80, 0), 3'd2, 8'hFF, 1'b1, 4'd5, 3'd2, 3'd7, "R9 set wins");
        step(1'b1, mk(4, 8'h01, 0), 3'd0, 8'hFF, 1'b1, 4'd9, 3'd6, 3'd6, "R9 distinct bits");
        // R10: idle cycles
        repeat (3) step(1'b0, 32'hFFFF_FFFF, 3'd7, 8'hFF, 1'b0, 4'd5, 3'd5, 3'd1, "R10 idle");

        // constrained random mix
        for (int k = 0; k < 600; k++) begin
            bit we = ($urandom % 4) != 0;
            bit ce = ($urandom % 3) == 0;
            logic [31:0] d = mk($urandom % 16, $urandom % 256, $urandom % 4)
                             | ($urandom & 32'hFC00_FFF0);
            logic [NC-1:0] en = NC'($urandom) | NC'($urandom);
            step(we, d, 3'($urandom), en, ce, 4'($urandom), 3'($urandom),
                 3'($urandom), "R7 random mix");
        end
        finish_run();
    end

endmodule